// File: doc/BRIEF.md
# PCI Interrupt Router with SCI Merge

This block takes eight level-sensitive PCI interrupt request lines, PIRQ A to H (numbered 0 to 7), and one ACPI system control interrupt (SCI) level. It drives them onto 24 interrupt outputs. Outputs 0 to 15 go to a legacy PIC. Outputs 16 to 23 go to an APIC.

Each PIRQ always drives its own APIC line. It can also drive one PIC line, chosen by a routing byte that software programs. Several PIRQs may share one PIC line, and the PIC route of any PIRQ can be turned off. A three-bit select field places the SCI on one of five lines, which may be PIC or APIC lines. When that select changes, the SCI is withheld from every line for one cycle, so the old line drops before the new one rises. All outputs are registered.

A separate combinational lookup port converts a device slot number and an INTx pin into the PIRQ number that the pin is wired to.

Top module: `irq_router`

## Requirements
- R1: PIC output k (0 to 15) is the OR of every PIRQ n whose routing byte has bit 7 clear and bits [3:0] equal to k. This holds even when several PIRQs select the same k.
- R2: A PIRQ whose routing byte has bit 7 set drives no PIC output, whatever its bits [3:0] hold.
- R3: APIC output 16+n follows PIRQ n whatever its routing byte holds. No two PIRQs share an APIC output.
- R4: The SCI select (register 8, bits [2:0]) chooses the SCI target. Code 0 selects line 9, code 1 line 10, code 2 line 11, code 4 line 20 and code 5 line 21. The SCI level is ORed into that line only.
- R5: Select codes 3, 6 and 7 are reserved. With any of them, the SCI drives no output.
- R6: A write that changes the select to a different code withholds the SCI from every output for one cycle. If the SCI is held high, the old line falls one cycle before the new line rises.
- R7: Every output is registered. It shows the inputs and registers of the previous clock cycle, and all outputs are 0 while reset is held.
- R8: After reset, all eight routing bytes read 0x80 (PIC routing off) and the SCI select reads 0.
- R9: Register addresses: 0 to 3 are the routing bytes of PIRQ A to D, 4 to 7 are those of PIRQ E to H, and 8 is the SCI select. A routing byte reads back exactly as written. The select reads as its three bits, zero-extended. Writes to addresses 9 to 15 change nothing, and reads from them return 0.
- R10: The lookup maps slot s and pin i (0 = INTA to 3 = INTD) to PIRQ ((s+i) mod 4)+4. Slot 30, the bridge's own slot, maps pin i to PIRQ 4+i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pirq_in | input | 8 | PIRQ levels, bit n = PIRQ n |
| sci_in | input | 1 | SCI level |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write byte |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 8 | Register read byte (combinational) |
| map_slot | input | 5 | Lookup: device slot |
| map_pin | input | 2 | Lookup: INTx pin |
| map_pirq | output | 3 | Lookup: PIRQ number |
| irq_out | output | 24 | Interrupt outputs: 0-15 PIC, 16-23 APIC |

## Verification
The assertions check on every cycle that each APIC line follows its PIRQ one cycle later, and that at most one line is the SCI target. They also check that a reserved select or the one-cycle gap leaves the SCI with no target, that a routing write is stored, and that the lookup always yields a PIRQ in the E to H half. Several behaviours are shown only by the bench's scenarios: PIC sharing between PIRQs, masking by the disable bit, the exact falling-then-rising sequence when the select moves while the SCI is held high, the reset values, the ignored addresses, and the bridge slot's special mapping. The bench compares each of these against its own model of the registers.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
   localparam int              ROUTE_W   = 8;
   localparam int              FIELD_W   = 4;
   localparam int              OFF_BIT   = 7;
   localparam logic [ROUTE_W-1:0] ROUTE_RST = 8'h80;
   localparam int              SEL_W     = 3;
   localparam int              LINE_W    = 5;

   typedef struct packed {
      logic              valid;
      logic [LINE_W-1:0] line;
   } sci_target_t;

   function automatic sci_target_t sci_decode(input logic [SEL_W-1:0] sel);
      sci_target_t t;
      t = '0;
      case (sel)
         3'd0: t = '{valid: 1'b1, line: 5'd9};
         3'd1: t = '{valid: 1'b1, line: 5'd10};
         3'd2: t = '{valid: 1'b1, line: 5'd11};
         3'd4: t = '{valid: 1'b1, line: 5'd20};
         3'd5: t = '{valid: 1'b1, line: 5'd21};
         default: t = '0;
      endcase
      return t;
   endfunction
endpackage

// File: rtl/irq_route_regs.sv
module irq_route_regs
   import irq_router_pkg::*;
#(
   parameter int N_PIRQ = 8,
   parameter int ADDR_W = 4
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             wr_en,
   input  logic [ADDR_W-1:0]                wr_addr,
   input  logic [ROUTE_W-1:0]               wr_data,
   input  logic [ADDR_W-1:0]                rd_addr,
   output logic [ROUTE_W-1:0]               rd_data,
   output logic [N_PIRQ-1:0][ROUTE_W-1:0]   route_o,
   output logic [SEL_W-1:0]                 sci_sel_o,
   output logic                             sci_gap_o
);
   localparam int                IDX_W    = $clog2(N_PIRQ);
   localparam logic [ADDR_W-1:0] SEL_ADDR = ADDR_W'(N_PIRQ);

   if ((1 << ADDR_W) <= N_PIRQ) begin : g_bad_addr
      $error("irq_route_regs: ADDR_W too small for routing bytes plus select");
   end

   logic [N_PIRQ-1:0][ROUTE_W-1:0] route_q;
   logic [SEL_W-1:0]               sel_q;
   logic                           gap_q;

   for (genvar n = 0; n < N_PIRQ; n++) begin : g_byte
      always_ff @(posedge clk) begin
         if (!rst_n)
            route_q[n] <= ROUTE_RST;
         else if (wr_en && wr_addr == ADDR_W'(n))
            route_q[n] <= wr_data;
      end

      // R9: a routing write lands in its byte
      a_r9_write_store: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && wr_addr == ADDR_W'(n)) |=> (route_q[n] == $past(wr_data)));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q <= '0;
         gap_q <= 1'b0;
      end else if (wr_en && wr_addr == SEL_ADDR) begin
         sel_q <= wr_data[SEL_W-1:0];
         gap_q <= (wr_data[SEL_W-1:0] != sel_q);
      end else begin
         gap_q <= 1'b0;
      end
   end

   always_comb begin
      rd_data = '0;
      if (rd_addr < SEL_ADDR)
         rd_data = route_q[rd_addr[IDX_W-1:0]];
      else if (rd_addr == SEL_ADDR)
         rd_data = ROUTE_W'(sel_q);
   end

   assign route_o   = route_q;
   assign sci_sel_o = sel_q;
   assign sci_gap_o = gap_q;
endmodule

// File: rtl/irq_level_merge.sv
module irq_level_merge
   import irq_router_pkg::*;
#(
   parameter int N_PIRQ = 8,
   parameter int N_PIC  = 16,
   localparam int N_OUT = N_PIC + N_PIRQ
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [N_PIRQ-1:0]              pirq_i,
   input  logic [N_PIRQ-1:0][ROUTE_W-1:0] route_i,
   input  logic                           sci_i,
   input  logic [N_OUT-1:0]               sci_tgt_i,
   output logic [N_OUT-1:0]               irq_o
);
   if (N_PIC > (1 << FIELD_W)) begin : g_bad_pic
      $error("irq_level_merge: N_PIC exceeds the routing field range");
   end

   logic [N_OUT-1:0] lvl;

   for (genvar k = 0; k < N_PIC; k++) begin : g_pic
      always_comb begin
         lvl[k] = sci_i & sci_tgt_i[k];
         for (int n = 0; n < N_PIRQ; n++) begin
            if (!route_i[n][OFF_BIT] && route_i[n][FIELD_W-1:0] == FIELD_W'(k))
               lvl[k] = lvl[k] | pirq_i[n];
         end
      end
   end

   for (genvar n = 0; n < N_PIRQ; n++) begin : g_apic
      assign lvl[N_PIC+n] = pirq_i[n] | (sci_i & sci_tgt_i[N_PIC+n]);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) irq_o <= '0;
      else        irq_o <= lvl;
   end
endmodule

// File: rtl/irq_slot_map.sv
module irq_slot_map #(
   parameter int SLOT_W      = 5,
   parameter int PIN_W       = 2,
   parameter int BRIDGE_SLOT = 30,
   localparam int PIRQ_W     = PIN_W + 1
) (
   input  logic [SLOT_W-1:0] slot_i,
   input  logic [PIN_W-1:0]  pin_i,
   output logic [PIRQ_W-1:0] pirq_o
);
   if (BRIDGE_SLOT >= (1 << SLOT_W)) begin : g_bad_slot
      $error("irq_slot_map: bridge slot out of slot range");
   end

   logic [PIN_W-1:0] rot;
   assign rot = slot_i[PIN_W-1:0] + pin_i;

   always_comb begin
      if (slot_i == SLOT_W'(BRIDGE_SLOT)) pirq_o = {1'b1, pin_i};
      else                                pirq_o = {1'b1, rot};
   end
endmodule

// File: rtl/irq_router.sv
module irq_router
   import irq_router_pkg::*;
#(
   parameter int N_PIRQ      = 8,
   parameter int N_PIC       = 16,
   parameter int ADDR_W      = 4,
   parameter int SLOT_W      = 5,
   parameter int BRIDGE_SLOT = 30,
   localparam int N_OUT      = N_PIC + N_PIRQ
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_PIRQ-1:0]  pirq_in,
   input  logic               sci_in,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [7:0]         wr_data,
   input  logic [ADDR_W-1:0]  rd_addr,
   output logic [7:0]         rd_data,
   input  logic [SLOT_W-1:0]  map_slot,
   input  logic [1:0]         map_pin,
   output logic [2:0]         map_pirq,
   output logic [N_OUT-1:0]   irq_out
);
   if (N_PIRQ != 8) begin : g_bad_pirq
      $error("irq_router: lookup assumes eight PIRQs");
   end
   if (N_OUT <= 21) begin : g_bad_out
      $error("irq_router: SCI lines 20 and 21 need at least 22 outputs");
   end

   logic [N_PIRQ-1:0][ROUTE_W-1:0] route;
   logic [SEL_W-1:0]               sci_sel;
   logic                           sci_gap;
   sci_target_t                    sci_t;
   logic [N_OUT-1:0]               sci_tgt;

   irq_route_regs #(.N_PIRQ(N_PIRQ), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .route_o(route), .sci_sel_o(sci_sel), .sci_gap_o(sci_gap)
   );

   assign sci_t   = sci_decode(sci_sel);
   assign sci_tgt = (sci_t.valid && !sci_gap) ? (N_OUT'(1) << sci_t.line) : '0;

   irq_level_merge #(.N_PIRQ(N_PIRQ), .N_PIC(N_PIC)) u_merge (
      .clk(clk), .rst_n(rst_n), .pirq_i(pirq_in), .route_i(route),
      .sci_i(sci_in), .sci_tgt_i(sci_tgt), .irq_o(irq_out)
   );

   irq_slot_map #(.SLOT_W(SLOT_W), .PIN_W(2), .BRIDGE_SLOT(BRIDGE_SLOT)) u_map (
      .slot_i(map_slot), .pin_i(map_pin), .pirq_o(map_pirq)
   );

   for (genvar n = 0; n < N_PIRQ; n++) begin : g_chk_apic
      // R3: APIC line follows its PIRQ one cycle later
      a_r3_apic_follow: assert property (@(posedge clk) disable iff (!rst_n)
         pirq_in[n] |=> irq_out[N_PIC+n]);
   end

   // R4: the SCI has at most one target line
   a_r4_sci_single: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sci_tgt));
   // R5: a reserved select leaves the SCI unrouted
   a_r5_reserved_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (sci_sel == 3'd3 || sci_sel == 3'd6 || sci_sel == 3'd7) |-> (sci_tgt == '0));
   // R6: during the gap cycle the SCI has no target
   a_r6_gap_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      sci_gap |-> (sci_tgt == '0));
   // R10: every lookup lands in PIRQ E to H
   a_r10_map_upper: assert property (@(posedge clk) disable iff (!rst_n)
      map_pirq[2]);
endmodule

// File: tb/irq_router_test.sv
`timescale 1ns/1ps
module irq_router_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  pirq_in = '0;
   logic        sci_in = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic [3:0]  rd_addr = '0;
   logic [7:0]  rd_data;
   logic [4:0]  map_slot = '0;
   logic [1:0]  map_pin = '0;
   logic [2:0]  map_pirq;
   logic [23:0] irq_out;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   logic [7:0] m_route [8];
   logic [2:0] m_sel;
   logic       m_gap;

   always #2.5 clk = ~clk;

   irq_router uut (
      .clk(clk), .rst_n(rst_n), .pirq_in(pirq_in), .sci_in(sci_in),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .map_slot(map_slot),
      .map_pin(map_pin), .map_pirq(map_pirq), .irq_out(irq_out)
   );

   function automatic int sci_line(input logic [2:0] s);
      case (s)
         3'd0: return 9;
         3'd1: return 10;
         3'd2: return 11;
         3'd4: return 20;
         3'd5: return 21;
         default: return -1;
      endcase
   endfunction

   function automatic logic [23:0] exp_out(input logic [7:0] p, input logic s);
      logic [23:0] e;
      int ln;
      e = '0;
      for (int k = 0; k < 16; k++)
         for (int n = 0; n < 8; n++)
            if (!m_route[n][7] && m_route[n][3:0] == 4'(k) && p[n]) e[k] = 1'b1;
      for (int n = 0; n < 8; n++) if (p[n]) e[16+n] = 1'b1;
      ln = sci_line(m_sel);
      if (s && !m_gap && ln >= 0) e[ln] = 1'b1;
      return e;
   endfunction

   function automatic logic [7:0] exp_rd(input logic [3:0] a);
      if (a < 4'd8)  return m_route[a[2:0]];
      if (a == 4'd8) return {5'b0, m_sel};
      return 8'h00;
   endfunction

   function automatic logic [2:0] exp_map(input logic [4:0] s, input logic [1:0] i);
      if (s == 5'd30) return 3'(4 + i);
      return 3'(4 + ((int'(s) + int'(i)) % 4));
   endfunction

   task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic step(input string req, input logic wen, input logic [3:0] wa,
                       input logic [7:0] wd, input logic [7:0] p, input logic s);
      logic [23:0] e;
      @(negedge clk);
      wr_en = wen; wr_addr = wa; wr_data = wd; pirq_in = p; sci_in = s;
      e = exp_out(p, s);
      if (wen && wa < 4'd8) begin
         m_route[wa[2:0]] = wd;
         m_gap = 1'b0;
      end else if (wen && wa == 4'd8) begin
         m_gap = (wd[2:0] != m_sel);
         m_sel = wd[2:0];
      end else begin
         m_gap = 1'b0;
      end
      @(posedge clk);
      #1;
      wr_en = 1'b0;
      check(req, irq_out, e);
   endtask

   task automatic probe(input string req, input logic [3:0] a, input logic [4:0] s,
                        input logic [1:0] i);
      rd_addr = a; map_slot = s; map_pin = i;
      #0.5;
      check({req, " read"}, 24'(rd_data), 24'(exp_rd(a)));
      check("R10 lookup", 24'(map_pirq), 24'(exp_map(s, i)));
   endtask

   initial begin
      #500us;
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h1CE5));
      for (int n = 0; n < 8; n++) m_route[n] = 8'h80;
      m_sel = 3'd0; m_gap = 1'b0;
      pirq_in = 8'hFF; sci_in = 1'b1;
      repeat (3) @(posedge clk);
      #1;
      check("R7 reset outputs low", irq_out, 24'h0);
      @(negedge clk); rst_n = 1'b1;
      for (int a = 0; a < 9; a++) probe("R8 reset value", 4'(a), 5'd0, 2'd0);

      // R2/R3: default disabled routing, only APIC plus SCI on line 9
      step("R2 R3 default", 1'b0, 4'd0, 8'h00, 8'hA5, 1'b1);
      // R1: PIRQ A and C share PIC line 5
      step("R9 write", 1'b1, 4'd0, 8'h05, 8'h00, 1'b0);
      step("R9 write", 1'b1, 4'd2, 8'h05, 8'h00, 1'b0);
      step("R1 share A", 1'b0, 4'd0, 8'h00, 8'h01, 1'b0);
      step("R1 share C", 1'b0, 4'd0, 8'h00, 8'h04, 1'b0);
      step("R1 share none", 1'b0, 4'd0, 8'h00, 8'h00, 1'b0);
      // R2: disable bit with a field still set
      step("R9 write", 1'b1, 4'd2, 8'h85, 8'h00, 1'b0);
      step("R2 disabled", 1'b0, 4'd0, 8'h00, 8'h04, 1'b0);
      probe("R9 read back", 4'd2, 5'd30, 2'd3);
      // R9: writes to an unused address are ignored
      step("R9 ignored write", 1'b1, 4'd11, 8'h3C, 8'h00, 1'b0);
      for (int a = 9; a < 16; a++) probe("R9 unused", 4'(a), 5'd30, 2'(a));
      probe("R9 route intact", 4'd0, 5'd7, 2'd1);
      // R6: move SCI from line 9 to 20 while held high
      step("R6 before move", 1'b1, 4'd8, 8'h04, 8'h00, 1'b1);
      step("R6 gap", 1'b0, 4'd0, 8'h00, 8'h00, 1'b1);
      if (irq_out[9] || irq_out[20]) $display("FAIL R6: actual line high expected both low");
      n_chk++; if (irq_out[9] || irq_out[20]) n_bad++;
      step("R4 line 20", 1'b0, 4'd0, 8'h00, 8'h00, 1'b1);
      // R4: rewriting the same code causes no gap
      step("R4 same code", 1'b1, 4'd8, 8'h04, 8'h00, 1'b1);
      step("R4 no gap", 1'b0, 4'd0, 8'h00, 8'h00, 1'b1);
      // R5: reserved codes
      step("R5 to reserved", 1'b1, 4'd8, 8'h06, 8'h00, 1'b1);
      step("R5 gap", 1'b0, 4'd0, 8'h00, 8'h00, 1'b1);
      step("R5 reserved", 1'b0, 4'd0, 8'h00, 8'h00, 1'b1);
      probe("R9 select read", 4'd8, 5'd0, 2'd0);

      for (int it = 0; it < 1500; it++) begin
         logic [3:0] a;
         logic       w;
         w = ($urandom % 3) == 0;
         a = ($urandom % 4 == 0) ? 4'd8 : 4'($urandom);
         step("R1 R3 R4 R7 random", w, a, 8'($urandom), 8'($urandom), 1'($urandom));
         probe("R9 random", 4'($urandom), 5'($urandom), 2'($urandom));
      end

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule